// File: doc/BRIEF.md
# TDM Frame Master Transmitter

This block drives a multi-slot time-division audio link as clock master. It produces the bit clock at half the rate of its input clock. It produces a frame-sync line, and it shifts parallel samples out serially, one sample per active slot, most significant bit first. Samples come in over a valid/ready handshake. A slot whose bit is clear in the slot mask carries zeros and takes no sample.

Configuration is sampled continuously while `enable` is low and frozen while it is high. It covers the word length (8, 16, 24 or 32 bits), the number of slots, the slot mask, the framing mode and an inversion of the frame-sync line. In the early-sync mode the sync pulse covers the final bit of the frame, so it leads the first slot by one bit. In the late-sync mode the sync pulse covers the first bit of slot 0. Internally the pulse is a half-open window between a start (slot, bit) position and an end (slot, bit) position, derived from the framing mode. The window may wrap across the frame boundary.

Top module: `tdm_frame_master`

## Requirements
- R1: While `enable` is low, and after reset, `bclk`, `fsync`, `sdata`, `sampleReady` and `underrun` are all low from the next clock edge on.
- R2: While enabled, `bclk` changes level on every clock edge. It is high after the first enabled edge, so one bit period spans two clocks. The first high phase is a lead-in that carries no data.
- R3: `sdata` and `fsync` change only on edges where `bclk` falls, so they are stable across every rising edge of `bclk`.
- R4: `cfgWordMode` selects the slot width as 8*(mode+1) bits: 0=8, 1=16, 2=24, 3=32. Each slot sends `sampleData[width-1:0]` starting with bit width-1.
- R5: A frame has `cfgSlotsM1`+1 slots, numbered from 0, of one word each. Frames follow each other with no gap.
- R6: `sampleReady` is high for exactly one clock, while `bclk` is high, just before the falling edge that starts an active slot. The sample is taken at that edge.
- R7: A slot whose bit in `cfgSlotMask` is 0 (bit i = slot i) sends all zeros and never raises `sampleReady`.
- R8: If `sampleValid` is low when an active slot starts, that slot sends zeros and `underrun` goes high. It stays high until `enable` is dropped.
- R9: With `cfgDspB`=0 (early sync), the non-inverted `fsync` is high only during the last bit of the last slot of each frame.
- R10: With `cfgDspB`=1 (late sync), the non-inverted `fsync` is high only during bit 0 of slot 0.
- R11: With `cfgFsInvert`=1, `fsync` is the complement of the level given by R9/R10 for every data bit period.
- R12: Changes to any configuration input while `enable` is high have no effect on the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the bit rate |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run; configuration is sampled while low |
| cfgWordMode | input | 2 | Slot width code, width = 8*(code+1) |
| cfgSlotsM1 | input | SLOT_W | Slots per frame minus one |
| cfgSlotMask | input | MAX_SLOTS | Active-slot mask, bit i = slot i |
| cfgDspB | input | 1 | 0: sync on last bit before frame, 1: sync on first bit |
| cfgFsInvert | input | 1 | Invert the frame-sync line |
| sampleData | input | 32 | Sample word, right-justified |
| sampleValid | input | 1 | Sample available |
| sampleReady | output | 1 | Sample taken at this edge |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Sticky: an active slot found no sample |

## Verification
The bench builds the block with its default of eight slots, so the slot field is three bits wide. This covers full eight-slot frames with sparse masks and 8-bit words, and also single-slot 32-bit frames. In the single-slot case the early-sync window wraps onto slot 0 itself. A 24-bit, three-slot case checks that frames wrap at a count that is not a power of two. Two directed runs cover the remaining cases. One starves the sample input to show zero-fill and the sticky flag. The other scrambles the configuration inputs in mid-stream.

// File: rtl/tdm_frame_pkg.sv
package tdm_frame_pkg;
  localparam int unsigned WORD_MAX = 32;
  localparam int unsigned BIT_W    = 5;

  // Strobes from the counter/control side to the serialiser
  typedef struct packed {
    logic advance;    // this edge is a bclk falling edge
    logic slotStart;  // the new position is bit 0 of a slot
    logic slotOn;     // the new slot is active in the mask
    logic fsNext;     // frame-sync level for the new position
  } tdm_strobe_t;
endpackage

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
  import tdm_frame_pkg::*;
#(
  parameter  int MAX_SLOTS = 8,
  localparam int SLOT_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int KEY_W     = SLOT_W + BIT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [1:0]           cfgWordMode,
  input  logic [SLOT_W-1:0]    cfgSlotsM1,
  input  logic [MAX_SLOTS-1:0] cfgSlotMask,
  input  logic                 cfgDspB,
  input  logic                 cfgFsInvert,
  output logic                 bclk,
  output logic [1:0]           wordMode,
  output tdm_strobe_t          strobe
);
  logic [SLOT_W-1:0]    slotsM1Q;
  logic [MAX_SLOTS-1:0] maskQ;
  logic                 dspBQ, invQ;
  logic                 phase, primed;
  logic [BIT_W-1:0]     bitCnt, nextBit, wlM1;
  logic [SLOT_W-1:0]    slotCnt, nextSlot;
  logic [KEY_W-1:0]     startKey, endKey, nextKey;
  logic                 inWin, advance;

  // Configuration is captured only while stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordMode <= '0;
      slotsM1Q <= '0;
      maskQ    <= '0;
      dspBQ    <= 1'b0;
      invQ     <= 1'b0;
    end else if (!enable) begin
      wordMode <= cfgWordMode;
      slotsM1Q <= cfgSlotsM1;
      maskQ    <= cfgSlotMask;
      dspBQ    <= cfgDspB;
      invQ     <= cfgFsInvert;
    end
  end

  assign wlM1    = {wordMode, 3'b111};
  assign advance = enable && phase;

  always_comb begin
    if (!primed || (bitCnt == wlM1 && slotCnt == slotsM1Q)) begin
      nextBit  = '0;
      nextSlot = '0;
    end else if (bitCnt == wlM1) begin
      nextBit  = '0;
      nextSlot = slotCnt + SLOT_W'(1);
    end else begin
      nextBit  = bitCnt + BIT_W'(1);
      nextSlot = slotCnt;
    end
  end

  // Frame-sync window [start, end) over the (slot, bit) position
  always_comb begin
    if (dspBQ) begin
      startKey = '0;
      endKey   = KEY_W'(1);
    end else begin
      startKey = {slotsM1Q, wlM1};
      endKey   = '0;
    end
    nextKey = {nextSlot, nextBit};
    if (startKey <= endKey) inWin = (nextKey >= startKey) && (nextKey < endKey);
    else                    inWin = (nextKey >= startKey) || (nextKey < endKey);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= 1'b0;
      primed  <= 1'b0;
      bitCnt  <= '0;
      slotCnt <= '0;
    end else if (!enable) begin
      phase   <= 1'b0;
      primed  <= 1'b0;
      bitCnt  <= '0;
      slotCnt <= '0;
    end else begin
      phase <= !phase;
      if (advance) begin
        primed  <= 1'b1;
        bitCnt  <= nextBit;
        slotCnt <= nextSlot;
      end
    end
  end

  assign bclk             = phase;
  assign strobe.advance   = advance;
  assign strobe.slotStart = (nextBit == '0);
  assign strobe.slotOn    = maskQ[nextSlot];
  assign strobe.fsNext    = inWin ^ invQ;

  p_idle_clock_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !bclk);
  p_bclk_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && bclk) |=> !bclk);
  p_bclk_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !bclk) |=> bclk);
  p_position_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> (slotCnt <= slotsM1Q && bitCnt <= wlM1));
  p_frame_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (advance && primed && bitCnt == wlM1 && slotCnt == slotsM1Q)
      |=> (bitCnt == '0 && slotCnt == '0));
  p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> ($stable(wordMode) && $stable(maskQ) && $stable(slotsM1Q)
                && $stable(dspBQ) && $stable(invQ)));
endmodule

// File: rtl/tdm_frame_dp.sv
module tdm_frame_dp
  import tdm_frame_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  tdm_strobe_t         strobe,
  input  logic [1:0]          wordMode,
  input  logic [WORD_MAX-1:0] sampleData,
  input  logic                sampleValid,
  output logic                sampleReady,
  output logic                sdata,
  output logic                fsync,
  output logic                underrun
);
  logic [WORD_MAX-1:0] shiftQ, aligned;
  logic                fsQ, underrunQ;

  // Left-justify the active word so the MSB leaves first
  always_comb begin
    unique case (wordMode)
      2'd0:    aligned = {sampleData[7:0],  24'b0};
      2'd1:    aligned = {sampleData[15:0], 16'b0};
      2'd2:    aligned = {sampleData[23:0], 8'b0};
      default: aligned = sampleData;
    endcase
  end

  assign sampleReady = strobe.advance && strobe.slotStart && strobe.slotOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ    <= '0;
      fsQ       <= 1'b0;
      underrunQ <= 1'b0;
    end else if (!enable) begin
      shiftQ    <= '0;
      fsQ       <= 1'b0;
      underrunQ <= 1'b0;
    end else if (strobe.advance) begin
      fsQ <= strobe.fsNext;
      if (strobe.slotStart) begin
        shiftQ <= (strobe.slotOn && sampleValid) ? aligned : '0;
        if (strobe.slotOn && !sampleValid) underrunQ <= 1'b1;
      end else begin
        shiftQ <= shiftQ << 1;
      end
    end
  end

  assign sdata    = shiftQ[WORD_MAX-1];
  assign fsync    = fsQ;
  assign underrun = underrunQ;

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sdata && !fsync && !underrun && !sampleReady));
  p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |=> !sampleReady);
  p_masked_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.slotStart && !strobe.slotOn) |=> !sdata);
  p_starved_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sampleReady && !sampleValid) |=> (!sdata && underrun));
  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && underrun) |=> underrun);
endmodule

// File: rtl/tdm_frame_master.sv
module tdm_frame_master
  import tdm_frame_pkg::*;
#(
  parameter  int MAX_SLOTS = 8,
  localparam int SLOT_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [1:0]           cfgWordMode,
  input  logic [SLOT_W-1:0]    cfgSlotsM1,
  input  logic [MAX_SLOTS-1:0] cfgSlotMask,
  input  logic                 cfgDspB,
  input  logic                 cfgFsInvert,
  input  logic [31:0]          sampleData,
  input  logic                 sampleValid,
  output logic                 sampleReady,
  output logic                 bclk,
  output logic                 fsync,
  output logic                 sdata,
  output logic                 underrun
);
  tdm_strobe_t strobe;
  logic [1:0]  wordMode;

  tdm_frame_ctrl #(.MAX_SLOTS(MAX_SLOTS)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .cfgWordMode(cfgWordMode),
    .cfgSlotsM1 (cfgSlotsM1),
    .cfgSlotMask(cfgSlotMask),
    .cfgDspB    (cfgDspB),
    .cfgFsInvert(cfgFsInvert),
    .bclk       (bclk),
    .wordMode   (wordMode),
    .strobe     (strobe)
  );

  tdm_frame_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .strobe     (strobe),
    .wordMode   (wordMode),
    .sampleData (sampleData),
    .sampleValid(sampleValid),
    .sampleReady(sampleReady),
    .sdata      (sdata),
    .fsync      (fsync),
    .underrun   (underrun)
  );

  p_edge_align_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bclk) |-> ($stable(sdata) && $stable(fsync)));
  p_ready_high_phase_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |-> bclk);
endmodule

// File: tb/tdm_frame_master_tb.sv
`timescale 1ns/1ps
module tdm_frame_master_tb_top;
  localparam int MAX_SLOTS = 8;
  localparam int SLOT_W    = 3;

  typedef struct packed {
    logic [1:0] mode;
    logic [2:0] slotsM1;
    logic [7:0] mask;
    logic       dspB;
    logic       inv;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{mode: 2'd1, slotsM1: 3'd1, mask: 8'h03, dspB: 1'b1, inv: 1'b0},
    '{mode: 2'd1, slotsM1: 3'd3, mask: 8'h0F, dspB: 1'b0, inv: 1'b0},
    '{mode: 2'd0, slotsM1: 3'd7, mask: 8'hA5, dspB: 1'b0, inv: 1'b1},
    '{mode: 2'd2, slotsM1: 3'd2, mask: 8'h05, dspB: 1'b1, inv: 1'b0},
    '{mode: 2'd3, slotsM1: 3'd0, mask: 8'h01, dspB: 1'b0, inv: 1'b0},
    '{mode: 2'd3, slotsM1: 3'd1, mask: 8'h02, dspB: 1'b1, inv: 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [1:0] cfgWordMode = '0;
  logic [SLOT_W-1:0] cfgSlotsM1 = '0;
  logic [MAX_SLOTS-1:0] cfgSlotMask = '0;
  logic cfgDspB = 1'b0;
  logic cfgFsInvert = 1'b0;
  logic [31:0] sampleData = '0;
  logic sampleValid = 1'b0;
  logic sampleReady, bclk, fsync, sdata, underrun;

  int checks = 0;
  int failures = 0;
  int sendIdx = 0;
  logic xfer = 1'b0;
  logic lastUnderrun;
  int lastReadies;

  always #10 clk = !clk;

  tdm_frame_master #(.MAX_SLOTS(MAX_SLOTS)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgWordMode(cfgWordMode), .cfgSlotsM1(cfgSlotsM1),
    .cfgSlotMask(cfgSlotMask), .cfgDspB(cfgDspB), .cfgFsInvert(cfgFsInvert),
    .sampleData(sampleData), .sampleValid(sampleValid),
    .sampleReady(sampleReady), .bclk(bclk), .fsync(fsync),
    .sdata(sdata), .underrun(underrun)
  );

  function automatic logic [31:0] sampleOf(int k);
    return (32'h9E37_79B9 * (k + 1)) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Sample source: new word after each accepted handshake
  always @(negedge clk) xfer <= sampleReady && sampleValid;
  initial forever begin
    @(posedge clk);
    #1;
    if (xfer) begin
      sendIdx++;
      sampleData = sampleOf(sendIdx);
    end
  end

  task automatic runConfig(input vec_t v, input int frames, input bit haveData,
                           input bit scramble, input string req);
    int wl, nb, target, s, b, useIdx, bclkErr, readies, actSlots;
    bit preamble, prevB, expD, expF;
    logic [31:0] curWord;
    enable = 1'b0;
    cfgWordMode = v.mode; cfgSlotsM1 = v.slotsM1; cfgSlotMask = v.mask;
    cfgDspB = v.dspB; cfgFsInvert = v.inv;
    sampleValid = haveData;
    repeat (3) @(negedge clk);
    sendIdx = 0; sampleData = sampleOf(0);
    wl = 8 * (int'(v.mode) + 1);
    target = frames * (int'(v.slotsM1) + 1) * wl;
    nb = 0; s = 0; b = 0; useIdx = 0; bclkErr = 0; readies = 0;
    preamble = 1'b1; prevB = 1'b0; curWord = '0;
    enable = 1'b1;
    forever begin
      @(negedge clk);
      if (bclk == prevB) bclkErr++;
      prevB = bclk;
      if (scramble && nb == 3) begin
        cfgWordMode = ~v.mode; cfgSlotsM1 = ~v.slotsM1; cfgSlotMask = ~v.mask;
        cfgDspB = ~v.dspB; cfgFsInvert = ~v.inv;
      end
      if (bclk) begin
        if (preamble) begin
          preamble = 1'b0;
          chk(!sdata && !fsync, "R2", "lead-in phase quiet", {fsync, sdata}, 0);
        end else begin
          if (b == 0) begin
            if (v.mask[s]) begin
              curWord = haveData ? sampleOf(useIdx) : 32'h0;
              useIdx++;
            end else curWord = 32'h0;
          end
          expD = curWord[wl - 1 - b];
          expF = (v.dspB ? (s == 0 && b == 0)
                         : (s == int'(v.slotsM1) && b == wl - 1)) ^ v.inv;
          chk(sdata == expD, req, $sformatf("R4 R5 R7 data slot %0d bit %0d", s, b),
              sdata, expD);
          chk(fsync == expF, req, $sformatf("R9 R10 R11 fsync slot %0d bit %0d", s, b),
              fsync, expF);
          nb++;
          if (b == wl - 1) begin
            b = 0;
            s = (s == int'(v.slotsM1)) ? 0 : s + 1;
          end else b++;
        end
      end
      if (nb == target) break;
      if (sampleReady) readies++;
    end
    lastUnderrun = underrun;
    enable = 1'b0;
    cfgWordMode = v.mode; cfgSlotsM1 = v.slotsM1; cfgSlotMask = v.mask;
    cfgDspB = v.dspB; cfgFsInvert = v.inv;
    actSlots = 0;
    for (int i = 0; i <= int'(v.slotsM1); i++) if (v.mask[i]) actSlots++;
    lastReadies = readies;
    chk(bclkErr == 0, "R2", "bclk toggles every clock", bclkErr, 0);
    chk(readies == frames * actSlots, "R6 R7", "ready pulses per run",
        readies, frames * actSlots);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bclk && !fsync && !sdata && !sampleReady && !underrun, "R1",
        "outputs during reset", {bclk, fsync, sdata, sampleReady, underrun}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!bclk && !fsync && !sdata && !sampleReady && !underrun, "R1",
        "outputs after reset, disabled", {bclk, fsync, sdata, sampleReady, underrun}, 0);

    // Table-driven runs
    for (int i = 0; i < NVEC; i++) begin
      runConfig(VECS[i], 3, 1'b1, 1'b0, "R4");
      chk(lastUnderrun == 1'b0, "R8", "no underrun with data ready", lastUnderrun, 0);
      @(negedge clk);
      chk(!bclk && !fsync && !sdata && !sampleReady, "R1", "lines low after disable",
          {bclk, fsync, sdata, sampleReady}, 0);
    end

    // R8: starved input -> zeros and sticky flag, cleared on disable
    runConfig('{mode: 2'd1, slotsM1: 3'd2, mask: 8'h06, dspB: 1'b0, inv: 1'b0},
              2, 1'b0, 1'b0, "R8");
    chk(lastUnderrun == 1'b1, "R8", "underrun set when starved", lastUnderrun, 1);
    @(negedge clk);
    chk(underrun == 1'b0, "R8", "underrun cleared by disable", underrun, 0);
    chk(lastReadies == 4, "R8", "starved slots still offered", lastReadies, 4);

    // R12: configuration inputs scrambled mid-stream
    runConfig('{mode: 2'd0, slotsM1: 3'd3, mask: 8'h0B, dspB: 1'b1, inv: 1'b0},
              3, 1'b1, 1'b1, "R12");
    @(negedge clk);
    chk(!bclk && !fsync && !sdata, "R1", "lines low after scrambled run",
        {bclk, fsync, sdata}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule